// File: doc/BRIEF.md
# Binary-Field Inversion Sequencer (GF(2^409))

This block computes the multiplicative inverse of a nonzero element of GF(2^409). The inverse is found as a^(2^409-2) with the Itoh-Tsujii method. The block contains no field arithmetic of its own. It steers one shared field multiplier, which it does not own and which returns a reduced product in the same cycle it is given operands. A squaring is issued to that multiplier as a product of a value with itself. The block needs exactly 408 squarings and 10 general products, one per clock.

A host loads an operand and pulses `start`. The sequencer then holds `mul_req` high for 418 consecutive cycles. In each of those cycles it presents two operands on `mul_a`/`mul_b` and takes the product back on `mul_p`. When the chain finishes, `done` pulses for one cycle and `inv_out` holds the inverse.

The exponent 2^408-1 is built along the chain of exponent lengths 1, 2, 3, 6, 12, 24, 48, 51, 102, 204, 408. Each link squares the running value once per added bit and then multiplies by a saved earlier value:
- The links to 2 and 3 use the operand itself.
- The link from 48 to 51 uses the saved length-3 value.
- Each doubling link uses the value held just before its squarings.

One closing squaring turns a^(2^408-1) into the inverse.

Top module: `gf_inv_seq`

## Requirements
- R1: After reset, `done`, `mul_req` and `inv_out` are all zero.
- R2: For any nonzero operand, `inv_out` after `done` is the inverse of the operand. Field elements are encoded with bit i as the coefficient of x^i, and the modulus polynomial is x^409 + x^87 + 1.
- R3: In every requested cycle that is a squaring, `mul_a` equals `mul_b`.
- R4: One inversion requests exactly 418 multiplier cycles, back to back: 408 squarings and 10 general products.
- R5: `done` rises 418 clock edges after the edge that samples `start`, and it is high for exactly one cycle.
- R6: While idle, `mul_req` is low and `inv_out` does not change until the next accepted `start`.
- R7: A `start` that arrives while an inversion is running is ignored. The running result and its timing are unchanged.
- R8: The inverse of the element 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inversion of `a_in` (accepted only when idle) |
| a_in | input | 409 | Operand to invert, nonzero |
| done | output | 1 | One-cycle pulse when `inv_out` is valid |
| inv_out | output | 409 | Inverse of the last accepted operand |
| mul_req | output | 1 | Multiplier operands are valid this cycle |
| mul_a | output | 409 | First multiplier operand |
| mul_b | output | 409 | Second multiplier operand |
| mul_p | input | 409 | Reduced product of `mul_a` and `mul_b`, same cycle |

## Verification
The assertions assume three things about the inputs:
- `mul_p` is a combinational function of the operands presented in the same cycle.
- `a_in` is nonzero whenever `start` is accepted.
- Any `start` seen while the block is busy is meant to be dropped, not queued.

The bench models the multiplier as a same-cycle reducing product that carries no state. It only draws operands with at least one bit set. It deliberately raises `start` in the middle of a running inversion so that the ignore path is exercised under those same assumptions.

// File: rtl/gf_inv_seq.sv
module gf_inv_seq #(
  parameter int M     = 409,
  parameter int NSTEP = 10,
  parameter int CW    = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a_in,
  output logic         done,
  output logic [M-1:0] inv_out,
  output logic         mul_req,
  output logic [M-1:0] mul_a,
  output logic [M-1:0] mul_b,
  input  logic [M-1:0] mul_p
);
  localparam int SW = $clog2(NSTEP + 1);
  localparam int QW = $clog2(M + 1);

  typedef enum logic [1:0] {IDLE, SQ, MUL, FIN} st_t;

  st_t           state;
  logic [SW-1:0] step;
  logic [CW-1:0] cnt;
  logic [M-1:0]  acc, keep, opnd, b3;
  logic [M-1:0]  src;

  function automatic logic [CW-1:0] sq_len(input logic [SW-1:0] s);
    case (s)
      0, 1:    sq_len = CW'(1);
      2, 6:    sq_len = CW'(3);
      3:       sq_len = CW'(6);
      4:       sq_len = CW'(12);
      5:       sq_len = CW'(24);
      7:       sq_len = CW'(51);
      8:       sq_len = CW'(102);
      default: sq_len = CW'(204);
    endcase
  endfunction

  always_comb begin
    if (step < SW'(2))       src = opnd;
    else if (step == SW'(6)) src = b3;
    else                     src = keep;
  end

  assign mul_req = (state != IDLE);
  assign mul_a   = acc;
  assign mul_b   = (state == MUL) ? src : acc;
  assign inv_out = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      step  <= '0;
      cnt   <= '0;
      acc   <= '0;
      keep  <= '0;
      opnd  <= '0;
      b3    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          acc   <= a_in;
          opnd  <= a_in;
          keep  <= a_in;
          step  <= '0;
          cnt   <= sq_len('0);
          state <= SQ;
        end
        SQ: begin
          acc <= mul_p;
          if (cnt == CW'(1)) state <= MUL;
          else               cnt   <= cnt - CW'(1);
        end
        MUL: begin
          acc  <= mul_p;
          keep <= mul_p;
          if (step == SW'(1)) b3 <= mul_p;
          if (step == SW'(NSTEP - 1)) state <= FIN;
          else begin
            step  <= step + SW'(1);
            cnt   <= sq_len(step + SW'(1));
            state <= SQ;
          end
        end
        default: begin
          acc   <= mul_p;
          done  <= 1'b1;
          state <= IDLE;
        end
      endcase
    end
  end

  logic [QW-1:0] n_sq;
  logic [SW-1:0] n_mul;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_sq  <= '0;
      n_mul <= '0;
    end else if (state == IDLE) begin
      if (start) begin
        n_sq  <= '0;
        n_mul <= '0;
      end
    end else if (state == MUL) n_mul <= n_mul + SW'(1);
    else                       n_sq  <= n_sq + QW'(1);
  end

  p_square_same_ops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ || state == FIN) |-> mul_a == mul_b);

  p_op_totals_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (n_sq == QW'(M - 1) && n_mul == SW'(NSTEP)));

  p_mul_after_sq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MUL) |-> $past(state) == SQ);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && !start) |=> ($stable(inv_out) && !mul_req));

  p_busy_ignores_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_req && start && state != FIN) |=> mul_req);
endmodule

// File: tb/gf_inv_seq_test.sv
module gf_inv_seq_test;
  localparam int M = 409;
  localparam int TAP = 87;
  localparam time TCLK = 10;
  localparam int WATCH = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [M-1:0] a_in = '0;
  logic         done;
  logic [M-1:0] inv_out, mul_a, mul_b, mul_p;
  logic         mul_req;

  int checks = 0;
  int fails = 0;

  always #(TCLK / 2) clk = ~clk;

  function automatic logic [M-1:0] gfmul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      logic top = r[M-1];
      r = r << 1;
      if (top) begin
        r[0]   = ~r[0];
        r[TAP] = ~r[TAP];
      end
      if (y[i]) r = r ^ x;
    end
    return r;
  endfunction

  assign mul_p = gfmul(mul_a, mul_b);

  gf_inv_seq #(.M(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in),
    .done(done), .inv_out(inv_out), .mul_req(mul_req),
    .mul_a(mul_a), .mul_b(mul_b), .mul_p(mul_p)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [M-1:0] rand_elem();
    logic [M-1:0] v = '0;
    for (int i = 0; i < M; i += 32) v = (v << 32) | M'($urandom);
    if (v == '0) v[0] = 1'b1;
    return v;
  endfunction

  task automatic run_inv(input logic [M-1:0] a, input bit poke, input string tag);
    int lat = 0, reqs = 0, eqs = 0;
    logic [M-1:0] res;
    a_in = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 2000) begin
      if (mul_req) reqs++;
      if (mul_req && mul_a == mul_b) eqs++;
      if (poke && lat == 100) begin
        start = 1'b1;
        a_in = rand_elem();
      end
      if (poke && lat == 103) start = 1'b0;
      @(negedge clk);
      lat++;
    end
    res = inv_out;
    check(gfmul(a, res) == M'(1), tag, "a*inv == 1", longint'(gfmul(a, res) == M'(1)), 1);
    check(lat == 419, "R5", "done latency (negedges)", lat, 419);
    check(reqs == 418, "R4", "request cycles", reqs, 418);
    check(eqs >= 408, "R3", "equal-operand cycles", eqs, 408);
    @(negedge clk);
    check(!done, "R5", "done high one cycle only", done, 0);
    check(!mul_req, "R6", "no request when idle", mul_req, 0);
    for (int k = 0; k < 5; k++) @(negedge clk);
    check(inv_out == res, "R6", "result stable while idle", longint'(inv_out == res), 1);
  endtask

  task automatic t_reset();
    check(!done && !mul_req && inv_out == '0, "R1", "reset state",
          longint'(done) + longint'(mul_req) + longint'(inv_out != '0), 0);
  endtask

  task automatic t_one();
    run_inv(M'(1), 1'b0, "R8");
    check(inv_out == M'(1), "R8", "inverse of one", longint'(inv_out == M'(1)), 1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 4; n++) run_inv(rand_elem(), 1'b0, "R2");
  endtask

  task automatic t_patterns();
    logic [M-1:0] t;
    t = '0; t[M-1] = 1'b1;
    run_inv(t, 1'b0, "R2");
    run_inv({M{1'b1}}, 1'b0, "R2");
    t = '0; t[1] = 1'b1;
    run_inv(t, 1'b0, "R2");
  endtask

  task automatic t_busy_start();
    run_inv(rand_elem(), 1'b1, "R7");
  endtask

  initial begin
    #(TCLK * WATCH);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one();
    t_random();
    t_patterns();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule